// File: doc/BRIEF.md
# Branch Target and Next-PC Resolver

This unit decides where a 32-bit RISC core fetches next after a control-transfer instruction. The decode stage presents one instruction per cycle: the current program counter, register A, register B, the immediate and a set of control fields. One clock later the unit returns the resolved next PC, whether control left the sequential path, whether the following instruction must run before the redirect takes effect, a link value for the destination register with its write strobe, and pulses that set or clear the break-in-progress and interrupt-enable bits of the machine status register.

Four operation groups are handled. Jumps are unconditional, relative or absolute, and may link. Conditional branches test register A as a signed number against zero. Break operations always jump to an absolute address, link and mark a break in progress. Return operations jump to register A plus the immediate and may re-enable interrupts or end a break. Instructions are 4 bytes wide, so the sequential successor is PC + 4. Fetch, flushing and register writeback stay with the surrounding pipeline.

Top module: `bnpc_unit`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `done_o`, `taken_o`, `delay_pending_o`, `link_we_o`, `bip_set_o`, `bip_clr_o`, `ie_set_o`, `next_pc_o` and `link_val_o` are all zero.
- R2: For `kind_i` = 1 (conditional), `cond_i` selects a signed test of `reg_a_i` against zero: 0 equal, 1 not equal, 2 less than, 3 less or equal, 4 greater than, 5 greater or equal; codes 6 and 7 are never taken.
- R3: A conditional branch whose test fails reports `taken_o` = 0 and `next_pc_o` = `pc_i` + 4.
- R4: The operand is `imm_i` when `use_imm_i` = 1 and `reg_b_i` otherwise; for a taken jump (`kind_i` = 0) or taken conditional branch, `next_pc_o` is the operand when `absolute_i` = 1 and `pc_i` + operand (modulo 2^32) when it is 0.
- R5: A jump with `link_i` = 1 raises `link_we_o` with `link_val_o` = `pc_i`; a conditional branch never raises `link_we_o`, whatever `link_i` holds.
- R6: For jumps and conditional branches `delay_pending_o` equals `delay_i`, whether or not a conditional branch is taken.
- R7: A break (`kind_i` = 2) is taken to the operand as an absolute address, ignoring `absolute_i` and `delay_i`; it raises `link_we_o` with `link_val_o` = `pc_i`, raises `bip_set_o` and keeps `delay_pending_o` low.
- R8: A return (`kind_i` = 3) is taken to `reg_a_i` + `imm_i` regardless of `use_imm_i`, always raises `delay_pending_o` and never links; `ret_sel_i` = 1 raises `ie_set_o`, 2 raises `bip_clr_o`, 0 and 3 change no status bit.
- R9: Results appear one clock after `issue_i` is sampled high, marked by `done_o`; in a cycle after `issue_i` was low, `done_o` and every strobe are low and `next_pc_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | A control-transfer instruction is presented this cycle |
| kind_i | input | 2 | Operation group: 0 jump, 1 conditional, 2 break, 3 return |
| cond_i | input | 3 | Condition code for conditional branches |
| absolute_i | input | 1 | Target is the operand itself rather than PC + operand |
| link_i | input | 1 | Jump writes its own address to the destination register |
| delay_i | input | 1 | Jump or conditional branch has a delay slot |
| use_imm_i | input | 1 | Operand comes from the immediate instead of register B |
| ret_sel_i | input | 2 | Return flavour: 0 plain, 1 from interrupt, 2 from break |
| pc_i | input | 32 | Address of the instruction |
| reg_a_i | input | 32 | Register A: tested value, or return base |
| reg_b_i | input | 32 | Register B operand |
| imm_i | input | 32 | Sign-extended immediate |
| done_o | output | 1 | Outputs below belong to the instruction issued last cycle |
| next_pc_o | output | 32 | Resolved next program counter |
| taken_o | output | 1 | Control leaves the sequential path |
| delay_pending_o | output | 1 | Following instruction runs before the redirect |
| link_we_o | output | 1 | Write `link_val_o` to the destination register |
| link_val_o | output | 32 | Address of the instruction being resolved |
| bip_set_o | output | 1 | Set break-in-progress status bit |
| bip_clr_o | output | 1 | Clear break-in-progress status bit |
| ie_set_o | output | 1 | Set interrupt-enable status bit |

## Verification
Every result is registered exactly once, so a fault in the condition decoder, the target adder or the side-effect decode is visible on the ports in the cycle right after the offending issue, with no later state to mask it. A wrong sign or zero decision shows as a swapped `taken_o` together with a `next_pc_o` that is either PC + 4 or the branch target, which is why each condition is driven at -1, 0 and +1. A misrouted group decode shows as a status pulse, link strobe or delay flag on an operation that must not produce one, and the bench looks at all of them on every vector.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;

  typedef enum logic [1:0] {
    KIND_JUMP  = 2'd0,
    KIND_COND  = 2'd1,
    KIND_BREAK = 2'd2,
    KIND_RET   = 2'd3
  } br_kind_e;

  typedef enum logic [2:0] {
    CC_EQ  = 3'd0,
    CC_NE  = 3'd1,
    CC_LT  = 3'd2,
    CC_LE  = 3'd3,
    CC_GT  = 3'd4,
    CC_GE  = 3'd5,
    CC_RS6 = 3'd6,
    CC_RS7 = 3'd7
  } br_cond_e;

  typedef enum logic [1:0] {
    RET_PLAIN = 2'd0,
    RET_INTR  = 2'd1,
    RET_BRK   = 2'd2,
    RET_RSV   = 2'd3
  } ret_sel_e;

  typedef struct packed {
    logic taken;
    logic delay;
    logic link_we;
    logic bip_set;
    logic bip_clr;
    logic ie_set;
  } br_side_t;

endpackage

// File: rtl/bnpc_cond.sv
module bnpc_cond
  import bnpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] val_i,
  input  br_cond_e        cond_i,
  output logic            hit_o,
  output logic            is_neg_o,
  output logic            is_zero_o
);

  localparam int SIGN_BIT = XLEN - 1;

  function automatic logic test_cc(input br_cond_e cc, input logic neg, input logic zero);
    logic r;
    case (cc)
      CC_EQ:   r = zero;
      CC_NE:   r = !zero;
      CC_LT:   r = neg;
      CC_LE:   r = neg || zero;
      CC_GT:   r = !neg && !zero;
      CC_GE:   r = !neg;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  always_comb begin
    is_neg_o  = val_i[SIGN_BIT];
    is_zero_o = (val_i == '0);
    hit_o     = test_cc(cond_i, is_neg_o, is_zero_o);
  end

endmodule

// File: rtl/bnpc_target.sv
module bnpc_target
  import bnpc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] reg_a_i,
  input  logic [XLEN-1:0] reg_b_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic            use_imm_i,
  input  logic            absolute_i,
  input  br_kind_e        kind_i,
  input  logic            hit_i,
  output logic [XLEN-1:0] operand_o,
  output logic [XLEN-1:0] seq_pc_o,
  output logic [XLEN-1:0] next_pc_o
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  function automatic logic [XLEN-1:0] pick_target(
      input logic [XLEN-1:0] base, input logic [XLEN-1:0] opnd, input logic abs_mode);
    return abs_mode ? opnd : (base + opnd);
  endfunction

  function automatic logic [XLEN-1:0] fall_through(input logic [XLEN-1:0] base);
    return base + STEP;
  endfunction

  logic [XLEN-1:0] jump_tgt;
  logic [XLEN-1:0] ret_tgt;

  always_comb begin
    operand_o = use_imm_i ? imm_i : reg_b_i;
    seq_pc_o  = fall_through(pc_i);
    jump_tgt  = pick_target(pc_i, operand_o, absolute_i);
    ret_tgt   = reg_a_i + imm_i;
    case (kind_i)
      KIND_JUMP:  next_pc_o = jump_tgt;
      KIND_COND:  next_pc_o = hit_i ? jump_tgt : seq_pc_o;
      KIND_BREAK: next_pc_o = operand_o;
      default:    next_pc_o = ret_tgt;
    endcase
  end

endmodule

// File: rtl/bnpc_ctrl.sv
module bnpc_ctrl
  import bnpc_pkg::*;
(
  input  br_kind_e kind_i,
  input  ret_sel_e ret_sel_i,
  input  logic     hit_i,
  input  logic     link_i,
  input  logic     delay_i,
  output br_side_t side_o
);

  function automatic br_side_t decode_side(
      input br_kind_e k, input ret_sel_e rs, input logic hit, input logic lnk, input logic dly);
    br_side_t s;
    s = '0;
    case (k)
      KIND_JUMP: begin
        s.taken   = 1'b1;
        s.delay   = dly;
        s.link_we = lnk;
      end
      KIND_COND: begin
        s.taken = hit;
        s.delay = dly;
      end
      KIND_BREAK: begin
        s.taken   = 1'b1;
        s.link_we = 1'b1;
        s.bip_set = 1'b1;
      end
      default: begin
        s.taken   = 1'b1;
        s.delay   = 1'b1;
        s.ie_set  = (rs == RET_INTR);
        s.bip_clr = (rs == RET_BRK);
      end
    endcase
    return s;
  endfunction

  always_comb side_o = decode_side(kind_i, ret_sel_i, hit_i, link_i, delay_i);

endmodule

// File: rtl/bnpc_unit.sv
module bnpc_unit
  import bnpc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_i,
  input  logic [1:0]      kind_i,
  input  logic [2:0]      cond_i,
  input  logic            absolute_i,
  input  logic            link_i,
  input  logic            delay_i,
  input  logic            use_imm_i,
  input  logic [1:0]      ret_sel_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] reg_a_i,
  input  logic [XLEN-1:0] reg_b_i,
  input  logic [XLEN-1:0] imm_i,
  output logic            done_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o,
  output logic            delay_pending_o,
  output logic            link_we_o,
  output logic [XLEN-1:0] link_val_o,
  output logic            bip_set_o,
  output logic            bip_clr_o,
  output logic            ie_set_o
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  br_kind_e kind_w;
  br_cond_e cond_w;
  ret_sel_e ret_w;

  assign kind_w = br_kind_e'(kind_i);
  assign cond_w = br_cond_e'(cond_i);
  assign ret_w  = ret_sel_e'(ret_sel_i);

  // named internal events, visible to the assertions below
  logic            cond_hit;
  logic            a_neg;
  logic            a_zero;
  logic [XLEN-1:0] operand_w;
  logic [XLEN-1:0] seq_pc_w;
  logic [XLEN-1:0] next_pc_w;
  br_side_t        side_w;

  bnpc_cond #(.XLEN(XLEN)) u_cond (
    .val_i     (reg_a_i),
    .cond_i    (cond_w),
    .hit_o     (cond_hit),
    .is_neg_o  (a_neg),
    .is_zero_o (a_zero)
  );

  bnpc_target #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_target (
    .pc_i       (pc_i),
    .reg_a_i    (reg_a_i),
    .reg_b_i    (reg_b_i),
    .imm_i      (imm_i),
    .use_imm_i  (use_imm_i),
    .absolute_i (absolute_i),
    .kind_i     (kind_w),
    .hit_i      (cond_hit),
    .operand_o  (operand_w),
    .seq_pc_o   (seq_pc_w),
    .next_pc_o  (next_pc_w)
  );

  bnpc_ctrl u_ctrl (
    .kind_i    (kind_w),
    .ret_sel_i (ret_w),
    .hit_i     (cond_hit),
    .link_i    (link_i),
    .delay_i   (delay_i),
    .side_o    (side_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o          <= 1'b0;
      next_pc_o       <= '0;
      taken_o         <= 1'b0;
      delay_pending_o <= 1'b0;
      link_we_o       <= 1'b0;
      link_val_o      <= '0;
      bip_set_o       <= 1'b0;
      bip_clr_o       <= 1'b0;
      ie_set_o        <= 1'b0;
    end else begin
      done_o <= issue_i;
      if (issue_i) begin
        next_pc_o       <= next_pc_w;
        taken_o         <= side_w.taken;
        delay_pending_o <= side_w.delay;
        link_we_o       <= side_w.link_we;
        link_val_o      <= pc_i;
        bip_set_o       <= side_w.bip_set;
        bip_clr_o       <= side_w.bip_clr;
        ie_set_o        <= side_w.ie_set;
      end else begin
        taken_o         <= 1'b0;
        delay_pending_o <= 1'b0;
        link_we_o       <= 1'b0;
        bip_set_o       <= 1'b0;
        bip_clr_o       <= 1'b0;
        ie_set_o        <= 1'b0;
      end
    end
  end

  // a failed signed test must fall through by one instruction
  assert_fallthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !taken_o) |-> (next_pc_o == $past(pc_i) + STEP));

  // the link value is always the address of the resolved instruction
  assert_link_pc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |-> (done_o && link_val_o == $past(pc_i)));

  // break: taken, linked, never delayed
  assert_break_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bip_set_o |-> (taken_o && link_we_o && !delay_pending_o));

  // a return always carries a delay slot and never links
  assert_return_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && kind_w == KIND_RET) |=> (delay_pending_o && !link_we_o && taken_o));

  // at most one status-bit update per instruction
  assert_status_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bip_set_o, bip_clr_o, ie_set_o}));

  // idle cycle: nothing reported, target held
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> (!done_o && !taken_o && !link_we_o && $stable(next_pc_o)));

  // the decoder never reports both sign and zero for reg A
  assert_sign_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_neg && a_zero));

endmodule

// File: tb/sim_bnpc_unit.sv
`timescale 1ns/1ps
module sim_bnpc_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_i = 1'b0;
  logic [1:0]  kind_i = '0;
  logic [2:0]  cond_i = '0;
  logic        absolute_i = 1'b0;
  logic        link_i = 1'b0;
  logic        delay_i = 1'b0;
  logic        use_imm_i = 1'b0;
  logic [1:0]  ret_sel_i = '0;
  logic [31:0] pc_i = '0, reg_a_i = '0, reg_b_i = '0, imm_i = '0;
  logic        done_o, taken_o, delay_pending_o, link_we_o, bip_set_o, bip_clr_o, ie_set_o;
  logic [31:0] next_pc_o, link_val_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bnpc_unit u0 (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .kind_i(kind_i), .cond_i(cond_i),
    .absolute_i(absolute_i), .link_i(link_i), .delay_i(delay_i), .use_imm_i(use_imm_i),
    .ret_sel_i(ret_sel_i), .pc_i(pc_i), .reg_a_i(reg_a_i), .reg_b_i(reg_b_i), .imm_i(imm_i),
    .done_o(done_o), .next_pc_o(next_pc_o), .taken_o(taken_o),
    .delay_pending_o(delay_pending_o), .link_we_o(link_we_o), .link_val_o(link_val_o),
    .bip_set_o(bip_set_o), .bip_clr_o(bip_clr_o), .ie_set_o(ie_set_o)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [2:0]  cc;
    logic        ab;
    logic        lk;
    logic        dl;
    logic        ui;
    logic [1:0]  rs;
    logic [31:0] pc;
    logic [31:0] ra;
    logic [31:0] rb;
    logic [31:0] im;
    logic [31:0] e_pc;
    logic        e_tk;
    logic        e_dl;
    logic        e_lw;
    logic        e_bs;
    logic        e_bc;
    logic        e_ie;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    // R4 jump relative, register B
    '{2'd0,3'd0,1'b0,1'b0,1'b0,1'b0,2'd0,32'h1000,32'h0,32'h20,32'h0,       32'h1020,1,0,0,0,0,0},
    // R4 R5 R6 jump absolute immediate, linked, delayed
    '{2'd0,3'd0,1'b1,1'b1,1'b1,1'b1,2'd0,32'h2000,32'h0,32'h5,32'h8000,     32'h8000,1,1,1,0,0,0},
    // R4 jump relative with negative immediate
    '{2'd0,3'd0,1'b0,1'b0,1'b0,1'b1,2'd0,32'h100,32'h0,32'h0,32'hFFFFFFF0,  32'h000000F0,1,0,0,0,0,0},
    // R7 break: absolute_i and delay_i ignored
    '{2'd2,3'd0,1'b0,1'b0,1'b1,1'b0,2'd0,32'h400,32'h7,32'h18,32'h0,        32'h18,1,0,1,1,0,0},
    // R7 break from immediate
    '{2'd2,3'd1,1'b0,1'b0,1'b0,1'b1,2'd0,32'h404,32'h0,32'h0,32'h60,        32'h60,1,0,1,1,0,0},
    // R8 plain return, use_imm_i=0 still uses immediate
    '{2'd3,3'd0,1'b0,1'b1,1'b0,1'b0,2'd0,32'h700,32'h3000,32'h999,32'h8,    32'h3008,1,1,0,0,0,0},
    // R8 return from interrupt
    '{2'd3,3'd0,1'b0,1'b0,1'b0,1'b1,2'd1,32'h704,32'h3100,32'h0,32'h4,      32'h3104,1,1,0,0,0,1},
    // R8 return from break
    '{2'd3,3'd0,1'b0,1'b0,1'b0,1'b1,2'd2,32'h708,32'h3200,32'h0,32'hFFFFFFFC,32'h31FC,1,1,0,0,1,0},
    // R5 conditional with link_i set never links
    '{2'd1,3'd0,1'b0,1'b1,1'b0,1'b1,2'd0,32'h900,32'h0,32'h0,32'h40,        32'h940,1,0,0,0,0,0},
    // R2 reserved condition code never taken
    '{2'd1,3'd6,1'b0,1'b0,1'b0,1'b1,2'd0,32'hA00,32'h0,32'h0,32'h40,        32'hA04,0,0,0,0,0,0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    issue_i = 1'b1; kind_i = v.kind; cond_i = v.cc; absolute_i = v.ab; link_i = v.lk;
    delay_i = v.dl; use_imm_i = v.ui; ret_sel_i = v.rs;
    pc_i = v.pc; reg_a_i = v.ra; reg_b_i = v.rb; imm_i = v.im;
    @(negedge clk);
    issue_i = 1'b0;
  endtask

  task automatic check_vec(input vec_t v, input string req);
    chk(done_o == 1'b1, {req, " done"}, 32'(done_o), 32'd1);
    chk(next_pc_o == v.e_pc, {req, " next_pc"}, next_pc_o, v.e_pc);
    chk(taken_o == v.e_tk, {req, " taken"}, 32'(taken_o), 32'(v.e_tk));
    chk(delay_pending_o == v.e_dl, {req, " delay"}, 32'(delay_pending_o), 32'(v.e_dl));
    chk(link_we_o == v.e_lw, {req, " link_we"}, 32'(link_we_o), 32'(v.e_lw));
    if (v.e_lw) chk(link_val_o == v.pc, {req, " link_val"}, link_val_o, v.pc);
    chk({bip_set_o, bip_clr_o, ie_set_o} == {v.e_bs, v.e_bc, v.e_ie}, {req, " status"},
        32'({bip_set_o, bip_clr_o, ie_set_o}), 32'({v.e_bs, v.e_bc, v.e_ie}));
  endtask

  function automatic bit model_take(input int c, input int signed a);
    case (c)
      0: return a == 0;
      1: return a != 0;
      2: return a < 0;
      3: return a <= 0;
      4: return a > 0;
      5: return a >= 0;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state while held
    chk({done_o, taken_o, delay_pending_o, link_we_o, bip_set_o, bip_clr_o, ie_set_o} == 7'd0,
        "R1 strobes in reset", 32'({done_o, taken_o, delay_pending_o, link_we_o}), 32'd0);
    chk(next_pc_o == 32'd0 && link_val_o == 32'd0, "R1 values in reset", next_pc_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done_o == 1'b0 && next_pc_o == 32'd0, "R1 first cycle after reset", next_pc_o, 32'd0);

    // directed table
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      check_vec(VECS[i], $sformatf("R4/R7/R8 vec%0d", i));
    end

    // R2 R3 R6: every condition at -1, 0, +1, with and without delay slot
    for (int c = 0; c < 6; c++) begin
      for (int k = 0; k < 3; k++) begin
        for (int d = 0; d < 2; d++) begin
          vec_t v;
          int signed a;
          bit tk;
          a = k - 1;
          tk = model_take(c, a);
          v = '0;
          v.kind = 2'd1; v.cc = 3'(c); v.dl = 1'(d); v.ui = 1'b1; v.lk = 1'b1;
          v.pc = 32'h5000 + 32'(c * 64 + k * 8 + d * 4);
          v.ra = 32'(a); v.rb = 32'h1234; v.im = 32'h40;
          v.e_tk = tk; v.e_dl = 1'(d);
          v.e_pc = tk ? v.pc + 32'h40 : v.pc + 32'd4;
          drive(v);
          check_vec(v, $sformatf("R2 R3 R6 cc%0d a=%0d d%0d", c, a, d));
        end
      end
    end

    // R4 conditional absolute target from register B
    begin
      vec_t v;
      v = '0;
      v.kind = 2'd1; v.cc = 3'd5; v.ab = 1'b1; v.pc = 32'h6000; v.ra = 32'h7FFFFFFF;
      v.rb = 32'hC000; v.im = 32'h11; v.e_pc = 32'hC000; v.e_tk = 1'b1;
      drive(v);
      check_vec(v, "R4 cond absolute");
    end

    // R2 most negative value against greater-or-equal
    begin
      vec_t v;
      v = '0;
      v.kind = 2'd1; v.cc = 3'd5; v.ui = 1'b1; v.pc = 32'h6100; v.ra = 32'h80000000;
      v.im = 32'h80; v.e_pc = 32'h6104; v.e_tk = 1'b0;
      drive(v);
      check_vec(v, "R2 min negative");
    end

    // R9 idle cycle: strobes drop, next_pc holds
    @(negedge clk);
    chk(done_o == 1'b0 && taken_o == 1'b0, "R9 idle strobes", 32'({done_o, taken_o}), 32'd0);
    chk(next_pc_o == 32'h6104, "R9 idle hold", next_pc_o, 32'h6104);

    // R1 reset again after activity
    rst_n = 1'b0;
    @(negedge clk);
    chk(next_pc_o == 32'd0 && done_o == 1'b0, "R1 re-reset", next_pc_o, 32'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule